// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host read and write a small internal register file over a four-wire serial link. The link has an active-low select, a serial clock, a data input and a data output. Every access is one fixed frame of 16 serial clocks. The first bit picks read or write, seven address bits follow least significant bit first, and an eight-bit data byte closes the frame, also least significant bit first. A mode input switches the whole serial path and the interrupt on or off.

The serial pins are brought into the block's system clock domain through synchronizer chains, and edges of the serial clock are found there. The host must therefore run the serial clock slowly compared with the system clock, so that each half period lasts several system clocks. Read data is launched on falling serial edges 8 to 15, so the host samples it on rising edges 9 to 16. An active-low interrupt goes low when any alarm input changes, and it is released by a complete read of the status address.

Top module: `serial_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, `int_n` is high and `sdo` is 0.
- R2: A frame with bit 1 = 0 (write), whose 16th rising serial edge arrives while select is low, stores data bits 9..16 (bit 9 = D0) in the register selected by address bits 2..8 (bit 2 = A0). The new value appears on `regs_o[8*a +: 8]`.
- R3: In a frame with bit 1 = 1 (read), `sdo` carries D0..D7 of the addressed register. It changes on falling edges 8..15 and is valid at rising edges 9..16.
- R4: If select rises before the 16th rising edge, no register changes. The next frame decodes from bit 1.
- R5: Rising edges after the 16th within one select-low period are ignored: no second write happens.
- R6: `sdo` is 0 while select is high and throughout a write frame.
- R7: While `host_mode` is 0, frames have no effect on any register and `int_n` stays high.
- R8: In host mode, any change of any `alarm_i` bit, in either direction, drives `int_n` low.
- R9: A complete read of address 0x40 returns the alarm inputs in its low bits (zeros above) and releases `int_n` at the end of the frame. A read of any other address leaves `int_n` low.
- R10: Addresses from NUM_REGS (8) up, other than 0x40, read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 enables the serial path and the interrupt |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo | output | 1 | Serial read data out |
| int_n | output | 1 | Active-low alarm interrupt |
| alarm_i | input | 4 | Alarm status inputs |
| regs_o | output | 64 | All registers, register a at bits 8a+7..8a |

## Verification
The checker watches every cycle for four things. Registers must stay unchanged whenever the path is idle or out of host mode. A write commit may fire only on the last rising edge of a frame. The bit counter must never pass the frame length. An alarm change in host mode must pull the interrupt low on the next cycle. Only the bench's scenarios can show the rest: that serial bit order maps to the right address and data, that the read bits reach the output at the right edges, that aborted and over-long frames leave the registers intact, and that only a read of the status address releases the interrupt.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
   localparam int CMD_BITS = 1;
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } frame_phase_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= RST_VAL;
               else        st[i] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= RST_VAL;
               else        st[i] <= st[i-1];
         end
      end
   endgenerate
   assign q = st[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame
   import serial_reg_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   localparam int FRAME_LEN = CMD_BITS + ADDR_W + DATA_W,
   localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic              rise,
   input  logic              fall,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              done_o,
   output logic              rw_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              sdo_o,
   output logic [CNT_W-1:0]  cnt_o
);
   logic [CNT_W-1:0]  cnt;
   logic              rw_q;
   logic [ADDR_W-1:0] addr_sh;
   logic [DATA_W-1:0] dat_sh;
   logic [DATA_W-1:0] rd_sh;
   logic              sdo_q;
   frame_phase_e      phase;
   logic [ADDR_W-1:0] addr_nxt;
   logic [DATA_W-1:0] dat_nxt;

   assign addr_nxt = {sdi, addr_sh[ADDR_W-1:1]};
   assign dat_nxt  = {sdi, dat_sh[DATA_W-1:1]};

   always_comb begin
      if (cnt == '0)                       phase = PH_CMD;
      else if (cnt <= CNT_W'(ADDR_W))      phase = PH_ADDR;
      else                                 phase = PH_DATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         rw_q    <= 1'b0;
         addr_sh <= '0;
         dat_sh  <= '0;
         rd_sh   <= '0;
         sdo_q   <= 1'b0;
      end else if (!act) begin
         cnt   <= '0;
         rw_q  <= 1'b0;
         sdo_q <= 1'b0;
      end else begin
         if (rise && (cnt < CNT_W'(FRAME_LEN))) begin
            cnt <= cnt + 1'b1;
            unique case (phase)
               PH_CMD:  rw_q    <= sdi;
               PH_ADDR: addr_sh <= addr_nxt;
               default: dat_sh  <= dat_nxt;
            endcase
            if ((cnt == CNT_W'(ADDR_W)) && rw_q) rd_sh <= rd_data_i;
         end
         if (fall && rw_q && (cnt > CNT_W'(ADDR_W)) && (cnt < CNT_W'(FRAME_LEN))) begin
            sdo_q <= rd_sh[0];
            rd_sh <= rd_sh >> 1;
         end
      end
   end

   assign rd_addr_o = addr_nxt;
   assign done_o    = act && rise && (cnt == CNT_W'(FRAME_LEN - 1));
   assign rw_o      = rw_q;
   assign addr_o    = addr_sh;
   assign wdata_o   = dat_nxt;
   assign sdo_o     = sdo_q;
   assign cnt_o     = cnt;
endmodule

// File: rtl/srs_regbank.sv
module srs_regbank #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int NUM_REGS = 8,
   parameter int NUM_ALARM = 4,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h40
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic [NUM_ALARM-1:0]       status,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);
   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                                  regs[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))   regs[g] <= wr_data;
         assign regs_o[g*DATA_W +: DATA_W] = regs[g];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == STATUS_ADDR) rd_data = DATA_W'(status);
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
   end
endmodule

// File: rtl/srs_irq.sv
module srs_irq #(
   parameter int NUM_ALARM = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host,
   input  logic [NUM_ALARM-1:0] alarm_s,
   input  logic                 clr,
   output logic                 chg_o,
   output logic                 int_n
);
   logic [NUM_ALARM-1:0] prev;
   logic                 pend;

   assign chg_o = |(alarm_s ^ prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         pend <= 1'b0;
      end else begin
         prev <= alarm_s;
         if (!host)      pend <= 1'b0;
         else if (chg_o) pend <= 1'b1;
         else if (clr)   pend <= 1'b0;
      end
   end
   assign int_n = ~pend;
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
   import serial_reg_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int NUM_REGS = 8,
   parameter int NUM_ALARM = 4,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h40,
   localparam int FRAME_LEN = CMD_BITS + ADDR_W + DATA_W,
   localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_mode,
   input  logic                       cs_n,
   input  logic                       sclk,
   input  logic                       sdi,
   output logic                       sdo,
   output logic                       int_n,
   input  logic [NUM_ALARM-1:0]       alarm_i,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
         $error("NUM_REGS exceeds address space");
      end
      if (int'(STATUS_ADDR) < NUM_REGS) begin : g_bad_status
         $error("STATUS_ADDR overlaps the register file");
      end
      if (NUM_ALARM > DATA_W) begin : g_bad_alarm
         $error("NUM_ALARM wider than data byte");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [3:0]           pin_s;
   logic                 host_s, cs_n_s, sclk_s, sdi_s, sclk_d;
   logic [NUM_ALARM-1:0] alarm_s;
   logic                 act, rise, fall;
   logic [DATA_W-1:0]    rd_data;
   logic [ADDR_W-1:0]    rd_addr, fr_addr;
   logic [DATA_W-1:0]    fr_wdata;
   logic                 fr_done, fr_rw;
   logic                 wr_en, stat_clr, alarm_chg;
   logic [CNT_W-1:0]     bit_cnt;

   srs_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d({host_mode, cs_n, sclk, sdi}), .q(pin_s));
   assign {host_s, cs_n_s, sclk_s, sdi_s} = pin_s;

   srs_sync #(.W(NUM_ALARM), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_alarm_sync (
      .clk(clk), .rst_n(rst_n), .d(alarm_i), .q(alarm_s));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;

   assign act  = host_s && !cs_n_s;
   assign rise = sclk_s && !sclk_d;
   assign fall = !sclk_s && sclk_d;

   srs_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .act(act), .rise(rise), .fall(fall), .sdi(sdi_s),
      .rd_data_i(rd_data), .rd_addr_o(rd_addr), .done_o(fr_done), .rw_o(fr_rw),
      .addr_o(fr_addr), .wdata_o(fr_wdata), .sdo_o(sdo), .cnt_o(bit_cnt));

   assign wr_en    = fr_done && !fr_rw;
   assign stat_clr = fr_done && fr_rw && (fr_addr == STATUS_ADDR);

   srs_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                 .NUM_ALARM(NUM_ALARM), .STATUS_ADDR(STATUS_ADDR)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(fr_addr), .wr_data(fr_wdata),
      .rd_addr(rd_addr), .status(alarm_s), .rd_data(rd_data), .regs_o(regs_o));

   srs_irq #(.NUM_ALARM(NUM_ALARM)) u_irq (
      .clk(clk), .rst_n(rst_n), .host(host_s), .alarm_s(alarm_s), .clr(stat_clr),
      .chg_o(alarm_chg), .int_n(int_n));
endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk #(
   parameter int DATA_W = 8,
   parameter int NUM_REGS = 8,
   parameter int FRAME_LEN = 16,
   parameter int CNT_W = 5
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       act,
   input logic                       host_s,
   input logic                       alarm_chg,
   input logic                       wr_en,
   input logic [CNT_W-1:0]           bit_cnt,
   input logic                       sdo,
   input logic                       int_n,
   input logic [NUM_REGS*DATA_W-1:0] regs_o
);
   p_no_write_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> $stable(regs_o));

   p_hw_mode_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !host_s |=> (int_n && $stable(regs_o)));

   p_commit_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bit_cnt == CNT_W'(FRAME_LEN)));

   p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_LEN));

   p_sdo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> !sdo);

   p_int_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_chg && host_s) |=> !int_n);
endmodule

bind serial_reg_slave serial_reg_slave_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .act(act), .host_s(host_s), .alarm_chg(alarm_chg),
   .wr_en(wr_en), .bit_cnt(bit_cnt), .sdo(sdo), .int_n(int_n), .regs_o(regs_o));

// File: tb/sim_serial_reg_slave.sv
`timescale 1ns/1ps
module sim_serial_reg_slave;
   localparam int HALF = 8;
   localparam int NV = 10;
   // {rw, addr[6:0], data[7:0], expected read[7:0]}
   localparam logic [23:0] VEC [NV] = '{
      {1'b0, 7'h00, 8'hA5, 8'h00},
      {1'b0, 7'h03, 8'h3C, 8'h00},
      {1'b0, 7'h07, 8'hFF, 8'h00},
      {1'b1, 7'h00, 8'h00, 8'hA5},
      {1'b1, 7'h03, 8'h00, 8'h3C},
      {1'b1, 7'h07, 8'h00, 8'hFF},
      {1'b1, 7'h01, 8'h00, 8'h00},
      {1'b0, 7'h20, 8'h55, 8'h00},
      {1'b1, 7'h20, 8'h00, 8'h00},
      {1'b1, 7'h08, 8'h00, 8'h00}
   };

   logic clk = 0, rst_n = 0, host_mode = 1, cs_n = 1, sclk = 0, sdi = 0;
   logic [3:0]  alarm_i = 0;
   logic        sdo, int_n;
   logic [63:0] regs_o;
   logic [63:0] shadow;
   int checks = 0, errors = 0;
   logic [7:0] rd;
   logic       wr_sdo_seen;

   always #2 clk = ~clk;

   serial_reg_slave u0 (.clk(clk), .rst_n(rst_n), .host_mode(host_mode), .cs_n(cs_n),
      .sclk(sclk), .sdi(sdi), .sdo(sdo), .int_n(int_n), .alarm_i(alarm_i), .regs_o(regs_o));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] fbits(input logic rw, input logic [6:0] a, input logic [7:0] d);
      return {d, a, rw};
   endfunction

   task automatic xfer(input logic [31:0] bits, input int n, input logic is_wr);
      rd = 0;
      wr_sdo_seen = 0;
      @(negedge clk) cs_n = 0;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < n; k++) begin
         sdi = bits[k];
         repeat (HALF) @(negedge clk);
         if (k >= 8 && k < 16) rd[k-8] = sdo;
         if (is_wr && sdo) wr_sdo_seen = 1;
         sclk = 1;
         repeat (HALF) @(negedge clk);
         sclk = 0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1;
      repeat (2*HALF) @(negedge clk);
   endtask

   initial begin
      shadow = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (5) @(negedge clk);
      chk("R1 regs", regs_o, 64'h0);
      chk("R1 int_n", int_n, 1);
      chk("R1 sdo", sdo, 0);

      for (int v = 0; v < NV; v++) begin
         logic [23:0] e;
         e = VEC[v];
         xfer({16'h0, fbits(e[23], e[22:16], e[15:8])}, 16, !e[23]);
         if (!e[23]) begin
            if (e[22:16] < 8) shadow[e[22:16]*8 +: 8] = e[15:8];
            chk("R2 R10 write", regs_o, shadow);
            chk("R6 sdo in write", wr_sdo_seen, 0);
         end else begin
            chk("R3 R10 read", rd, e[7:0]);
         end
         chk("R6 sdo idle", sdo, 0);
      end

      // R4: abort after 12 bits
      xfer({16'h0, fbits(0, 7'h02, 8'h99)}, 12, 1);
      chk("R4 abort", regs_o, shadow);
      xfer({16'h0, fbits(1, 7'h03, 8'h00)}, 16, 0);
      chk("R4 next frame", rd, 8'h3C);

      // R5: 32 clocks under one select
      xfer({fbits(0, 7'h05, 8'h22), fbits(0, 7'h04, 8'h11)}, 32, 1);
      shadow[4*8 +: 8] = 8'h11;
      chk("R5 burst ignored", regs_o, shadow);

      // R8 / R9
      alarm_i = 4'b0010;
      repeat (8) @(negedge clk);
      chk("R8 int low", int_n, 0);
      xfer({16'h0, fbits(1, 7'h01, 8'h00)}, 16, 0);
      chk("R9 other read keeps int", int_n, 0);
      xfer({16'h0, fbits(1, 7'h40, 8'h00)}, 16, 0);
      chk("R9 status value", rd, 8'h02);
      chk("R9 int released", int_n, 1);
      alarm_i = 4'b0000;
      repeat (8) @(negedge clk);
      chk("R8 falling change", int_n, 0);
      xfer({16'h0, fbits(1, 7'h40, 8'h00)}, 16, 0);
      chk("R9 status zero", rd, 8'h00);
      chk("R9 int released 2", int_n, 1);

      // R7: hardware mode
      host_mode = 0;
      repeat (8) @(negedge clk);
      xfer({16'h0, fbits(0, 7'h06, 8'h77)}, 16, 1);
      chk("R7 no write", regs_o, shadow);
      alarm_i = 4'b1000;
      repeat (8) @(negedge clk);
      chk("R7 int high", int_n, 1);
      host_mode = 1;
      repeat (8) @(negedge clk);
      xfer({16'h0, fbits(1, 7'h06, 8'h00)}, 16, 0);
      chk("R7 reg6 untouched", rd, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule